// File: doc/BRIEF.md
# Six-Pin General Purpose I/O Port

This block is a register-mapped I/O port with six pins for a small microcontroller core. Software reaches it over a simple synchronous register bus that carries an address, a write strobe, write data and combinational read data. The bus exposes two registers. The port-data register returns the sampled pin levels on a read and loads the output latch on a write. The direction register picks, for each pin, whether the output driver is on or off.

Every pin slice drives an output enable and an output value toward its pad, and takes the pad's input level back through a two-stage synchronizer. Pin 3 can only be an input. Three side inputs change how the port behaves. A 3-bit oscillator-mode code takes pins 5 and 4 away from software in the crystal modes. A master-clear enable hides the level of pin 3. A per-pin analog mask makes analog pins read as zero.

Top module: `gpio6_port`

## Requirements
- R1: After reset the direction register reads 0x3F and all six output enables (`pad_oe_o`) are 0.
- R2: Outside the crystal modes, writing the direction register sets each stored bit for pins 0, 1, 2, 4 and 5. A stored 0 turns on that pin's output enable, with `pad_out_o` carrying the latch bit. A stored 1 turns the output enable off.
- R3: Direction bit 3 always reads 1 and `pad_oe_o[3]` is always 0, whatever value was written to bit 3.
- R4: For oscillator-mode codes 0, 1 and 2 (the crystal modes), direction bits 5 and 4 read 1 and `pad_oe_o[5:4]` are 0. The stored bits come back once the mode code is 3 to 7.
- R5: Reading the data register returns the pad levels through two flops. A change on `pad_in_i` appears in the read data after the second rising clock edge.
- R6: A write to the data register loads only the output latch. `pad_out_o` shows the written bits [5:0] from the next edge, and data-register reads still show the pad levels.
- R7: Read-data bits 7 and 6 are 0 for both registers.
- R8: With `mclr_en_i` high, data-register bit 3 reads 0.
- R9: A pin whose `analog_i` bit is 1 reads 0 in the data register, whatever its level.
- R10: The data register is at address 0 and the direction register at address 5. Every other address reads 0, and a write to such an address changes neither register.
- R11: Read data follows `addr_i` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| osc_mode_i | input | 3 | Oscillator-mode code; 0, 1 and 2 are the crystal modes |
| mclr_en_i | input | 1 | Pin 3 serves as master clear |
| analog_i | input | 6 | Per-pin analog-input mask |
| pad_in_i | input | 6 | Pad input levels |
| pad_oe_o | output | 6 | Pad output enables |
| pad_out_o | output | 6 | Pad output values (output latch) |

## Verification
On every cycle the assertions check four things. The output enable of pin 3 and of the crystal pins stays off. The output enables match the inverted direction read-back. The unimplemented read bits stay zero. Latch loads and ignored writes to unmapped addresses are also checked every cycle. The bench scenarios are needed for the rest. They sweep every direction value and every data value, and every oscillator code. They also sweep every pad pattern to check the two-edge synchronizer delay, and every analog mask. The scenarios also cover restoring the stored direction bits after a crystal mode ends and masking pin 3 for master clear.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  localparam int PORT_W = 6;
  localparam int REG_W  = 8;

  typedef enum logic [2:0] {
    OSC_LP     = 3'd0,
    OSC_XT     = 3'd1,
    OSC_HS     = 3'd2,
    OSC_EC     = 3'd3,
    OSC_INT_IO = 3'd4,
    OSC_INT_CK = 3'd5,
    OSC_RC_IO  = 3'd6,
    OSC_RC_CK  = 3'd7
  } osc_mode_e;

  function automatic logic is_xtal(input logic [2:0] mode);
    return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
  endfunction
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio6_slice.sv
module gpio6_slice #(
  parameter bit INPUT_ONLY = 1'b0,
  parameter bit XTAL_PIN   = 1'b0,
  parameter bit MCLR_PIN   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_we_i,
  input  logic data_we_i,
  input  logic wbit_i,
  input  logic xtal_mode_i,
  input  logic mclr_en_i,
  input  logic analog_i,
  input  logic pin_sync_i,
  output logic dir_rd_o,
  output logic data_rd_o,
  output logic oe_o,
  output logic out_o
);
  logic dir_q;
  logic latch_q;
  logic dir_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= 1'b1;
    else if (dir_we_i) dir_q <= wbit_i;
  end

  // latch has no reset: its value after power-up is undefined
  always_ff @(posedge clk_i) begin
    if (data_we_i) latch_q <= wbit_i;
  end

  always_comb begin
    dir_eff = dir_q;
    if (XTAL_PIN && xtal_mode_i) dir_eff = 1'b1;
    if (INPUT_ONLY)              dir_eff = 1'b1;
  end

  assign dir_rd_o  = dir_eff;
  assign oe_o      = ~dir_eff;
  assign out_o     = latch_q;
  assign data_rd_o = pin_sync_i & ~analog_i & ~(MCLR_PIN & mclr_en_i);
endmodule

// File: rtl/gpio6_regif.sv
module gpio6_regif
  import gpio6_pkg::*;
#(
  parameter int              ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd0,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 3'd5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [PORT_W-1:0] dir_rd_i,
  input  logic [PORT_W-1:0] data_rd_i,
  output logic              data_we_o,
  output logic              dir_we_o,
  output logic [PORT_W-1:0] wbits_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int PAD_W = REG_W - PORT_W;

  logic sel_data, sel_dir;
  logic [PAD_W-1:0] unused_hi;

  assign sel_data  = (addr_i == DATA_ADDR);
  assign sel_dir   = (addr_i == DIR_ADDR);
  assign data_we_o = we_i & sel_data;
  assign dir_we_o  = we_i & sel_dir;
  assign wbits_o   = wdata_i[PORT_W-1:0];
  assign unused_hi = wdata_i[REG_W-1:PORT_W];

  always_comb begin
    rdata_o = '0;
    if (sel_data)     rdata_o = {{PAD_W{1'b0}}, data_rd_i};
    else if (sel_dir) rdata_o = {{PAD_W{1'b0}}, dir_rd_i};
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int                ADDR_W      = 3,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 3'd0,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 3'd5,
  parameter int                SYNC_STAGES = 2,
  parameter int                IN_PIN      = 3,
  parameter int                XTAL_LO     = 4,
  parameter int                XTAL_HI     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [2:0]        osc_mode_i,
  input  logic              mclr_en_i,
  input  logic [5:0]        analog_i,
  input  logic [5:0]        pad_in_i,
  output logic [5:0]        pad_oe_o,
  output logic [5:0]        pad_out_o
);
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] dir_rd, data_rd, wbits;
  logic              data_we, dir_we, xtal_mode;

  assign xtal_mode = is_xtal(osc_mode_i);

  gpio6_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  gpio6_regif #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_regif (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .dir_rd_i  (dir_rd),
    .data_rd_i (data_rd),
    .data_we_o (data_we),
    .dir_we_o  (dir_we),
    .wbits_o   (wbits),
    .rdata_o   (rdata_o)
  );

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    gpio6_slice #(
      .INPUT_ONLY (i == IN_PIN),
      .XTAL_PIN   ((i == XTAL_LO) || (i == XTAL_HI)),
      .MCLR_PIN   (i == IN_PIN)
    ) u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dir_we_i    (dir_we),
      .data_we_i   (data_we),
      .wbit_i      (wbits[i]),
      .xtal_mode_i (xtal_mode),
      .mclr_en_i   (mclr_en_i),
      .analog_i    (analog_i[i]),
      .pin_sync_i  (pin_sync[i]),
      .dir_rd_o    (dir_rd[i]),
      .data_rd_o   (data_rd[i]),
      .oe_o        (pad_oe_o[i]),
      .out_o       (pad_out_o[i])
    );
  end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
  parameter int                ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd0,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 3'd5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [2:0]        osc_mode_i,
  input logic [5:0]        analog_i,
  input logic [5:0]        pad_oe_o,
  input logic [5:0]        pad_out_o
);
  assert_pin3_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[3]);

  assert_xtal_no_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_mode_i <= 3'd2) |-> (pad_oe_o[5:4] == 2'b00));

  assert_hi_bits_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:6] == 2'b00);

  assert_oe_matches_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DIR_ADDR) |-> (pad_oe_o == ~rdata_o[5:0]));

  assert_latch_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DATA_ADDR) |=> (pad_out_o == $past(wdata_i[5:0])));

  assert_unmapped_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != DATA_ADDR && addr_i != DIR_ADDR) |=> $stable(pad_out_o));

  assert_analog_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DATA_ADDR) |-> ((rdata_o[5:0] & analog_i) == 6'd0));
endmodule

bind gpio6_port gpio6_port_chk #(
  .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .osc_mode_i (osc_mode_i),
  .analog_i   (analog_i),
  .pad_oe_o   (pad_oe_o),
  .pad_out_o  (pad_out_o)
);

// File: tb/tb_gpio6_port.sv
`timescale 1ns/1ps
module tb_gpio6_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] osc_mode_i = 3'd5;
  logic       mclr_en_i = 1'b0;
  logic [5:0] analog_i = '0;
  logic [5:0] pad_in_i = '0;
  logic [5:0] pad_oe_o;
  logic [5:0] pad_out_o;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DIR  = 3'd5;

  always #4 clk_i = ~clk_i;

  gpio6_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .osc_mode_i(osc_mode_i),
    .mclr_en_i(mclr_en_i), .analog_i(analog_i), .pad_in_i(pad_in_i),
    .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  // R11: read data sampled with no clock edge after the address change
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic [7:0] e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(A_DIR, r);
    check("R1 dir reset", r, 8'h3F);
    check("R1 oe reset", {2'b0, pad_oe_o}, 8'h00);

    // R2/R3/R7/R11: every direction value
    for (int v = 0; v < 256; v += 1) begin
      wr(A_DIR, 8'(v));
      e = {2'b00, (6'(v) | 6'h08)};
      rd(A_DIR, r);
      check("R2 R3 R7 R11 dir read", r, e);
      check("R2 R3 oe", {2'b0, pad_oe_o}, {2'b0, ~e[5:0]});
    end

    // R4: every oscillator code with all stored bits at 0
    wr(A_DIR, 8'h00);
    for (int m = 0; m < 8; m++) begin
      osc_mode_i = 3'(m);
      e = (m <= 2) ? 8'h38 : 8'h08;
      rd(A_DIR, r);
      check("R4 dir read per mode", r, e);
      check("R4 oe per mode", {2'b0, pad_oe_o}, {2'b0, ~e[5:0]});
    end
    // R4: write while in crystal mode, stored bits return afterwards
    osc_mode_i = 3'd1;
    wr(A_DIR, 8'h0F);
    rd(A_DIR, r);
    check("R4 crystal read", r, 8'h3F);
    osc_mode_i = 3'd5;
    rd(A_DIR, r);
    check("R4 stored restore", r, 8'h0F);
    wr(A_DIR, 8'h00);

    // R6: every latch value; data read still shows pads
    pad_in_i = 6'h2A;
    repeat (3) @(negedge clk_i);
    for (int v = 0; v < 64; v++) begin
      wr(A_DATA, 8'(v));
      check("R6 pad_out", {2'b0, pad_out_o}, 8'(v));
      rd(A_DATA, r);
      check("R6 read shows pads", r, 8'h2A);
    end

    // R5: two-edge synchronizer delay for every pad pattern
    for (int p = 0; p < 64; p++) begin
      logic [5:0] prev;
      prev = pad_in_i;
      addr_i = A_DATA;
      @(negedge clk_i);
      pad_in_i = 6'(p);
      @(negedge clk_i);
      rd(A_DATA, r);
      check("R5 after one edge", r, {2'b0, prev});
      @(negedge clk_i);
      rd(A_DATA, r);
      check("R5 after two edges", r, 8'(p));
    end

    // R9: every analog mask
    pad_in_i = 6'h3F;
    repeat (3) @(negedge clk_i);
    for (int a = 0; a < 64; a++) begin
      analog_i = 6'(a);
      rd(A_DATA, r);
      check("R9 analog mask", r, {2'b0, ~6'(a)});
    end
    analog_i = '0;

    // R8: master clear hides pin 3
    mclr_en_i = 1'b1;
    rd(A_DATA, r);
    check("R8 mclr pin3", r, 8'h37);
    mclr_en_i = 1'b0;
    rd(A_DATA, r);
    check("R8 mclr off", r, 8'h3F);

    // R10: unmapped addresses
    wr(A_DIR, 8'h12);
    wr(A_DATA, 8'h15);
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a == 5) continue;
      wr(3'(a), 8'h00);
      rd(3'(a), r);
      check("R10 unmapped read", r, 8'h00);
      rd(A_DIR, r);
      check("R10 dir untouched", r, 8'h1A);
      check("R10 latch untouched", {2'b0, pad_out_o}, 8'h15);
    end

    finish_run();
  end
endmodule